// File: doc/BRIEF.md
# Per-Rank Activate Window Limiter

This block keeps, for every rank on a memory channel, a running tally of the row activates issued to that rank during the most recent window of memory bus cycles. The command scheduler pulses a single activate strobe with a rank index each time it opens a row. A refresh also opens a row, so it uses the same strobe. The block then raises a per-rank hold flag whenever four or more activates already lie inside the window. The scheduler reads that flag before it issues another activate to the rank. The block does not choose which command goes out.

The window length is an input sampled every cycle. A length of zero turns tracking off. Each rank keeps a shift register of recent activates, with one bit per cycle of the window, and a counter of the bits that are set. An activate writes the bit at the far end of the window. Bits move one place toward bit 0 each cycle. When a set bit leaves bit 0, the count drops by one. The count and the hold flag are both registered outputs.

Top module: `act_window_limiter`

## Requirements
- R1: A synchronous active-high reset clears every history, every count and every hold flag. After the reset edge all counts read 0 and `rank_hold` reads 0.
- R2: An activate strobe with rank index r and a nonzero window adds one to the count of rank r only. The new value is visible after the next rising clock edge.
- R3: With an effective window of W cycles, an activate taken at edge e is included in the count after edges e through e+W-1. It no longer counts after edge e+W.
- R4: `rank_hold[r]` is 1 exactly when the count of rank r is 4 or more.
- R5: When an activate to rank r and the expiry of an older activate of rank r fall on the same edge, the count of rank r is unchanged.
- R6: A window length of 0 disables tracking: activates are not recorded, and counts and hold flags stay as they were.
- R7: A window length above MAX_WIN (62 by default) is treated as MAX_WIN.
- R8: Rank r's count occupies bits [r*CNT_W +: CNT_W] of `rank_count`, with CNT_W = 6 by default. Activates to one rank never alter another rank's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory bus clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | One activate (row open or refresh) this cycle |
| act_rank | input | RANK_W (2) | Rank targeted by the activate |
| win_len | input | WIN_W (6) | Window length in cycles; 0 disables tracking |
| rank_hold | output | NUM_RANKS (4) | Per-rank flag: four or more activates in window |
| rank_count | output | NUM_RANKS*CNT_W (24) | Per-rank activate counts, packed |

## Verification
In a rank's register, a new activate and the expiry of an older one can land on the same edge. Two tests arrange this. The first uses a one-cycle window with an activate every cycle, which makes every activate coincide with the expiry of its predecessor. The second uses a longer window in a scripted sequence that repeats an activate exactly one window after an earlier one. In both tests the count must hold steady across the edge instead of stepping up or down. The same sequence also walks a rank up to four and back down, so the hold flag is seen to rise and fall with the count.

// File: rtl/faw_pkg.sv
package faw_pkg;

  // Limit of activates allowed inside one window per rank.
  localparam int unsigned ACT_LIMIT = 4;

  // Clamp a requested window length to the register depth.
  function automatic int unsigned clamp_window(input int unsigned req,
                                               input int unsigned depth);
    return (req > depth) ? depth : req;
  endfunction

endpackage

// File: rtl/act_mark_decode.sv
module act_mark_decode #(
  parameter int unsigned NUM_RANKS = 4,
  parameter int unsigned MAX_WIN   = 62,
  localparam int unsigned RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int unsigned WIN_W    = $clog2(MAX_WIN + 1)
) (
  input  logic                 act_valid,
  input  logic [RANK_W-1:0]    act_rank,
  input  logic [WIN_W-1:0]     win_len,
  output logic [NUM_RANKS-1:0] mark,
  output logic [MAX_WIN-1:0]   top_sel
);
  import faw_pkg::*;

  int unsigned eff_win;

  always_comb begin
    eff_win = clamp_window(int'(win_len), MAX_WIN);
    top_sel = '0;
    if (eff_win != 0) top_sel[eff_win-1] = 1'b1;
  end

  // One select line per rank; gated off when tracking is disabled.
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_sel
    assign mark[r] = act_valid && (eff_win != 0) && (act_rank == RANK_W'(r));
  end

endmodule

// File: rtl/rank_history.sv
module rank_history #(
  parameter int unsigned HIST_W = 62,
  parameter int unsigned LIMIT  = 4,
  localparam int unsigned CNT_W = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mark,
  input  logic [HIST_W-1:0] top_sel,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              hold_o
);

  logic [HIST_W-1:0] hist_q, hist_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              hold_q;

  always_comb begin
    hist_d = (hist_q >> 1) | (mark ? top_sel : '0);
    cnt_d  = cnt_q - CNT_W'(hist_q[0]) + CNT_W'(mark);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
      hold_q <= (cnt_d >= CNT_W'(LIMIT));
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;

  p_mark_lands_r2: assert property (@(posedge clk) disable iff (rst)
    mark |=> ((hist_q & $past(top_sel)) != '0));

  p_ageing_r3: assert property (@(posedge clk) disable iff (rst)
    !mark |=> (hist_q == ($past(hist_q) >> 1)));

  p_hold_tracks_r4: assert property (@(posedge clk) disable iff (rst)
    hold_q == (cnt_q >= CNT_W'(LIMIT)));

  p_net_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (mark && hist_q[0]) |=> (cnt_q == $past(cnt_q)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(HIST_W));

endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter int unsigned NUM_RANKS = 4,
  parameter int unsigned MAX_WIN   = 62,
  localparam int unsigned RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int unsigned WIN_W    = $clog2(MAX_WIN + 1),
  localparam int unsigned CNT_W    = $clog2(MAX_WIN + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       act_valid,
  input  logic [RANK_W-1:0]          act_rank,
  input  logic [WIN_W-1:0]           win_len,
  output logic [NUM_RANKS-1:0]       rank_hold,
  output logic [NUM_RANKS*CNT_W-1:0] rank_count
);
  import faw_pkg::*;

  logic [NUM_RANKS-1:0] mark_vec;
  logic [MAX_WIN-1:0]   top_sel;

  act_mark_decode #(
    .NUM_RANKS(NUM_RANKS),
    .MAX_WIN  (MAX_WIN)
  ) u_decode (
    .act_valid(act_valid),
    .act_rank (act_rank),
    .win_len  (win_len),
    .mark     (mark_vec),
    .top_sel  (top_sel)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    rank_history #(
      .HIST_W(MAX_WIN),
      .LIMIT (ACT_LIMIT)
    ) u_hist (
      .clk    (clk),
      .rst    (rst),
      .mark   (mark_vec[r]),
      .top_sel(top_sel),
      .cnt_o  (rank_count[r*CNT_W +: CNT_W]),
      .hold_o (rank_hold[r])
    );
  end

  p_single_rank_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mark_vec));

  p_zero_window_r6: assert property (@(posedge clk) disable iff (rst)
    (win_len == '0) |-> (mark_vec == '0));

  p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (act_valid && win_len != '0) |-> ($countones(top_sel) == 1));

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (rank_count == '0 && rank_hold == '0));

endmodule

// File: tb/act_window_limiter_bench.sv
`timescale 1ns/1ps
module act_window_limiter_bench;

  localparam int unsigned NR   = 4;
  localparam int unsigned CW   = 6;
  localparam int unsigned NVEC = 15;

  logic          clk = 1'b0;
  logic          rst;
  logic          act_valid;
  logic [1:0]    act_rank;
  logic [5:0]    win_len;
  logic [NR-1:0] rank_hold;
  logic [NR*CW-1:0] rank_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  act_window_limiter u_act_window_limiter (
    .clk(clk), .rst(rst), .act_valid(act_valid), .act_rank(act_rank),
    .win_len(win_len), .rank_hold(rank_hold), .rank_count(rank_count)
  );

  // {act, rank, expected count r0, expected count r1, expected hold}
  // window 5; each row checked after the edge that takes its stimulus
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 4'd1, 4'd0, 4'b0000},
    {1'b1, 2'd0, 4'd2, 4'd0, 4'b0000},
    {1'b1, 2'd1, 4'd2, 4'd1, 4'b0000},
    {1'b1, 2'd0, 4'd3, 4'd1, 4'b0000},
    {1'b1, 2'd0, 4'd4, 4'd1, 4'b0001},
    {1'b0, 2'd0, 4'd3, 4'd1, 4'b0000},
    {1'b1, 2'd0, 4'd3, 4'd1, 4'b0000},
    {1'b1, 2'd1, 4'd3, 4'd1, 4'b0000},
    {1'b0, 2'd0, 4'd2, 4'd1, 4'b0000},
    {1'b1, 2'd0, 4'd2, 4'd1, 4'b0000},
    {1'b1, 2'd0, 4'd3, 4'd1, 4'b0000},
    {1'b1, 2'd0, 4'd3, 4'd1, 4'b0000},
    {1'b1, 2'd0, 4'd4, 4'd0, 4'b0001},
    {1'b0, 2'd0, 4'd4, 4'd0, 4'b0001},
    {1'b0, 2'd0, 4'd3, 4'd0, 4'b0000}
  };

  function automatic int cnt_of(input int r);
    return int'(rank_count[r*CW +: CW]);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; act_valid = 1'b0; act_rank = '0; win_len = 6'd5;
    @(negedge clk); step(); step();
    // R1: reset state
    check("R1 counts after reset", int'(rank_count), 0);
    check("R1 hold after reset", int'(rank_hold), 0);
    rst = 1'b0;

    // Table walk: R2, R3, R4, R5, R8
    for (int i = 0; i < NVEC; i++) begin
      act_valid = VEC[i][14];
      act_rank  = VEC[i][13:12];
      step();
      check($sformatf("R2/R3/R5 rank0 count row %0d", i), cnt_of(0), int'(VEC[i][11:8]));
      check($sformatf("R8 rank1 count row %0d", i), cnt_of(1), int'(VEC[i][7:4]));
      check($sformatf("R4 hold row %0d", i), int'(rank_hold), int'(VEC[i][3:0]));
    end
    act_valid = 1'b0;
    for (int i = 0; i < 8; i++) step();
    check("R3 drained", int'(rank_count), 0);

    // R6: zero window records nothing
    win_len = 6'd0; act_valid = 1'b1; act_rank = 2'd3;
    for (int i = 0; i < 5; i++) step();
    check("R6 count with zero window", cnt_of(3), 0);
    check("R6 hold with zero window", int'(rank_hold), 0);
    act_valid = 1'b0;

    // R5: one-cycle window, activate every cycle, count steady
    win_len = 6'd1; act_rank = 2'd1; act_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      check("R5 net count window 1", cnt_of(1), 1);
    end
    act_valid = 1'b0;
    step();
    check("R3 window 1 expiry", cnt_of(1), 0);

    // R7: window 63 clamps to 62
    win_len = 6'd63; act_rank = 2'd2; act_valid = 1'b1;
    step();
    act_valid = 1'b0;
    check("R7 clamp first", cnt_of(2), 1);
    for (int i = 0; i < 61; i++) step();
    check("R7 clamp last cycle in window", cnt_of(2), 1);
    step();
    check("R7 clamp expired", cnt_of(2), 0);

    // R4 above limit, then R1 mid-run reset
    win_len = 6'd8; act_rank = 2'd0; act_valid = 1'b1;
    for (int i = 0; i < 5; i++) step();
    act_valid = 1'b0;
    check("R4 count five", cnt_of(0), 5);
    check("R4 hold above limit", int'(rank_hold[0]), 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 mid-run reset counts", int'(rank_count), 0);
    check("R1 mid-run reset hold", int'(rank_hold), 0);
    step();
    check("R1 history cleared", int'(rank_count), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule